// File: doc/BRIEF.md
# Serial Port Register Block

This block is the processor-facing register set of a simple byte-oriented serial port on a 32-bit bus. It is a word-addressed bus slave. It holds a status/data register pair for the receive direction and a second pair for the transmit direction. The same four registers answer at two base addresses, so software built for either memory layout runs unchanged.

On the terminal side, bytes arrive as a parallel byte with a one-cycle valid strobe. Bytes leave through a valid/ready handshake. Bit-level framing, baud timing and line signalling belong to other logic.

Two level-sensitive interrupt lines leave the block:
- The transmit line is meant for hardware interrupt 0 (cause bit 10).
- The receive line is meant for hardware interrupt 1 (cause bit 11).

Each line is gated by its own enable bit in the matching status register.

Top module: `serial_port_regs`

## Requirements
- R1: After reset the receive status reads 0x0, the transmit status reads 0x1, `tx_valid` is 0 and both interrupt lines are 0.
- R2: Register index is address bits [3:2]: 0 = receive status, 1 = receive data, 2 = transmit status, 3 = transmit data. The registers answer at base 0xFFFFC000 and identically at base 0xFFFF0000. An access outside both 16-byte windows reads 0 and changes nothing.
- R3: An `rx_valid` strobe stores `rx_byte`, and from the next cycle receive status bit 0 reads 1. A read of receive data returns the stored byte zero-extended to 32 bits.
- R4: A read of receive data clears receive status bit 0 from the next cycle. If a byte arrives in the same cycle as that read, the read returns the old byte, and the flag stays 1 with the new byte stored.
- R5: A byte arriving while the previous one is unread replaces it, and bit 0 stays 1.
- R6: Receive status bit 1 is a read/write enable. `irq_rx` is 1 exactly when that bit and bit 0 are both 1.
- R7: A write to transmit data while the port is ready raises `tx_valid` from the next cycle with `tx_byte` equal to bits [7:0] of the written word. Transmit status bit 0 reads 0 while that byte is pending.
- R8: `tx_valid` and `tx_byte` hold until a cycle with `tx_ready` high. From the following cycle `tx_valid` is 0 and transmit status bit 0 reads 1.
- R9: A write to transmit data while a byte is pending is dropped: no second byte is ever offered.
- R10: Transmit status bit 1 is a read/write enable. `irq_tx` is 1 exactly when that bit is 1 and transmit status bit 0 is 1.
- R11: Status bits 31:2 read 0. Writes to status bit 0 and writes to the receive data register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| rx_byte | input | 8 | Byte from the terminal side |
| rx_valid | input | 1 | One-cycle strobe for `rx_byte` |
| tx_byte | output | 8 | Byte toward the terminal side |
| tx_valid | output | 1 | `tx_byte` is offered |
| tx_ready | input | 1 | Terminal side accepts `tx_byte` |
| irq_tx | output | 1 | Transmit-ready interrupt level |
| irq_rx | output | 1 | Receive-available interrupt level |

## Verification
The bench builds the block with its default parameters: both window bases at their standard values and an 8-bit byte lane. With those values it can drive accesses into each window, and into an address just past the primary window, to show that aliasing and rejection both work. The 8-bit lane lets the bench write words with non-zero upper bits to transmit data and see them dropped at `tx_byte`. The timing corners of the register pairs are all driven directly: a receive read colliding with a byte arrival, an overwrite of an unread byte, and a write during a pending transmit.

// File: rtl/serial_port_pkg.sv
package serial_port_pkg;

    typedef enum logic [1:0] {
        REG_RX_STAT = 2'd0,
        REG_RX_DATA = 2'd1,
        REG_TX_STAT = 2'd2,
        REG_TX_DATA = 2'd3
    } sp_reg_e;

    typedef struct packed {
        logic    rd;
        logic    wr;
        sp_reg_e idx;
    } sp_access_t;

    localparam int STAT_RDY_BIT = 0;
    localparam int STAT_IE_BIT  = 1;

endpackage

// File: rtl/sp_window_decode.sv
module sp_window_decode
    import serial_port_pkg::*;
#(
    parameter int              ADDR_W       = 32,
    parameter logic [ADDR_W-1:0] PRIMARY_BASE = 32'hFFFF_C000,
    parameter logic [ADDR_W-1:0] MIRROR_BASE  = 32'hFFFF_0000
) (
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output sp_access_t        acc
);
    localparam int WIN_LSB   = 4;
    localparam int N_WINDOWS = 2;

    logic [N_WINDOWS-1:0] win_hit;

    for (genvar w = 0; w < N_WINDOWS; w++) begin : g_win
        localparam logic [ADDR_W-1:0] BASE = (w == 0) ? PRIMARY_BASE : MIRROR_BASE;
        assign win_hit[w] = (bus_addr[ADDR_W-1:WIN_LSB] == BASE[ADDR_W-1:WIN_LSB]);
    end

    always_comb begin
        acc.rd  = bus_sel && !bus_wr && (|win_hit);
        acc.wr  = bus_sel &&  bus_wr && (|win_hit);
        acc.idx = sp_reg_e'(bus_addr[WIN_LSB-1:2]);
    end

endmodule

// File: rtl/sp_rx_channel.sv
module sp_rx_channel
    import serial_port_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sp_access_t        acc,
    input  logic              wr_ie,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              rx_valid,
    output logic              rx_full,
    output logic              rx_ie,
    output logic [BYTE_W-1:0] rx_data
);
    typedef struct packed {
        logic              full;
        logic              ie;
        logic [BYTE_W-1:0] data;
    } rx_state_t;

    rx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (acc.wr && acc.idx == REG_RX_STAT) begin
            st_d.ie = wr_ie;
        end
        if (rx_valid) begin
            st_d.data = rx_byte;
            st_d.full = 1'b1;
        end else if (acc.rd && acc.idx == REG_RX_DATA) begin
            st_d.full = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rx_full = st_q.full;
    assign rx_ie   = st_q.ie;
    assign rx_data = st_q.data;

endmodule

// File: rtl/sp_tx_channel.sv
module sp_tx_channel
    import serial_port_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sp_access_t        acc,
    input  logic              wr_ie,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              tx_ready,
    output logic              tx_busy,
    output logic              tx_ie,
    output logic [BYTE_W-1:0] tx_data
);
    typedef struct packed {
        logic              busy;
        logic              ie;
        logic [BYTE_W-1:0] data;
    } tx_state_t;

    tx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (acc.wr && acc.idx == REG_TX_STAT) begin
            st_d.ie = wr_ie;
        end
        if (st_q.busy) begin
            if (tx_ready) begin
                st_d.busy = 1'b0;
            end
        end else if (acc.wr && acc.idx == REG_TX_DATA) begin
            st_d.busy = 1'b1;
            st_d.data = wr_byte;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_busy = st_q.busy;
    assign tx_ie   = st_q.ie;
    assign tx_data = st_q.data;

endmodule

// File: rtl/serial_port_regs.sv
module serial_port_regs
    import serial_port_pkg::*;
#(
    parameter int                ADDR_W       = 32,
    parameter int                DATA_W       = 32,
    parameter int                BYTE_W       = 8,
    parameter logic [ADDR_W-1:0] PRIMARY_BASE = 32'hFFFF_C000,
    parameter logic [ADDR_W-1:0] MIRROR_BASE  = 32'hFFFF_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              rx_valid,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic              irq_tx,
    output logic              irq_rx
);
    sp_access_t        acc;
    logic              rx_full, rx_ie, tx_busy, tx_ie;
    logic [BYTE_W-1:0] rx_data, tx_data;

    sp_window_decode #(
        .ADDR_W      (ADDR_W),
        .PRIMARY_BASE(PRIMARY_BASE),
        .MIRROR_BASE (MIRROR_BASE)
    ) u_dec (
        .bus_sel (bus_sel),
        .bus_wr  (bus_wr),
        .bus_addr(bus_addr),
        .acc     (acc)
    );

    sp_rx_channel #(.BYTE_W(BYTE_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc     (acc),
        .wr_ie   (bus_wdata[STAT_IE_BIT]),
        .rx_byte (rx_byte),
        .rx_valid(rx_valid),
        .rx_full (rx_full),
        .rx_ie   (rx_ie),
        .rx_data (rx_data)
    );

    sp_tx_channel #(.BYTE_W(BYTE_W)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc     (acc),
        .wr_ie   (bus_wdata[STAT_IE_BIT]),
        .wr_byte (bus_wdata[BYTE_W-1:0]),
        .tx_ready(tx_ready),
        .tx_busy (tx_busy),
        .tx_ie   (tx_ie),
        .tx_data (tx_data)
    );

    always_comb begin
        bus_rdata = '0;
        if (acc.rd) begin
            unique case (acc.idx)
                REG_RX_STAT: begin
                    bus_rdata[STAT_RDY_BIT] = rx_full;
                    bus_rdata[STAT_IE_BIT]  = rx_ie;
                end
                REG_RX_DATA: bus_rdata[BYTE_W-1:0] = rx_data;
                REG_TX_STAT: begin
                    bus_rdata[STAT_RDY_BIT] = !tx_busy;
                    bus_rdata[STAT_IE_BIT]  = tx_ie;
                end
                REG_TX_DATA: bus_rdata = '0;
                default:     bus_rdata = '0;
            endcase
        end
    end

    assign tx_valid = tx_busy;
    assign tx_byte  = tx_data;
    assign irq_rx   = rx_ie && rx_full;
    assign irq_tx   = tx_ie && !tx_busy;

endmodule

// File: rtl/sp_regs_checker.sv
module sp_regs_checker #(
    parameter int                ADDR_W       = 32,
    parameter int                DATA_W       = 32,
    parameter int                BYTE_W       = 8,
    parameter logic [ADDR_W-1:0] PRIMARY_BASE = 32'hFFFF_C000,
    parameter logic [ADDR_W-1:0] MIRROR_BASE  = 32'hFFFF_0000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              rx_valid,
    input logic [BYTE_W-1:0] tx_byte,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic              irq_tx,
    input logic              irq_rx
);
    logic in_win;
    logic rd_rx_data, rd_rx_stat, wr_tx_data;

    assign in_win = (bus_addr[ADDR_W-1:4] == PRIMARY_BASE[ADDR_W-1:4]) ||
                    (bus_addr[ADDR_W-1:4] == MIRROR_BASE[ADDR_W-1:4]);
    assign rd_rx_data = bus_sel && !bus_wr && in_win && (bus_addr[3:2] == 2'd1);
    assign rd_rx_stat = bus_sel && !bus_wr && in_win && (bus_addr[3:2] == 2'd0);
    assign wr_tx_data = bus_sel &&  bus_wr && in_win && (bus_addr[3:2] == 2'd3);

    p_rx_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> (!rd_rx_stat || bus_rdata[0]));

    p_rx_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rx_data && !rx_valid) |=> !irq_rx);

    p_tx_launch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_tx_data && !tx_valid) |=> (tx_valid && tx_byte == $past(bus_wdata[BYTE_W-1:0])));

    p_tx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte)));

    p_tx_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !tx_valid);

    p_irq_tx_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tx |-> !tx_valid);

    p_stat_upper_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_rx_stat |-> (bus_rdata[DATA_W-1:2] == '0));

endmodule

bind serial_port_regs sp_regs_checker #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .BYTE_W      (BYTE_W),
    .PRIMARY_BASE(PRIMARY_BASE),
    .MIRROR_BASE (MIRROR_BASE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .rx_valid (rx_valid),
    .tx_byte  (tx_byte),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .irq_tx   (irq_tx),
    .irq_rx   (irq_rx)
);

// File: tb/serial_port_regs_test.sv
`timescale 1ns/1ps
module serial_port_regs_test;
    localparam logic [31:0] PRI = 32'hFFFF_C000;
    localparam logic [31:0] MIR = 32'hFFFF_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [31:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
    logic [7:0]  rx_byte = '0, tx_byte;
    logic        rx_valid = 1'b0, tx_valid, tx_ready = 1'b0, irq_tx, irq_rx;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    serial_port_regs uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_byte(rx_byte), .rx_valid(rx_valid), .tx_byte(tx_byte),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .irq_tx(irq_tx), .irq_rx(irq_rx)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        #1;
    endtask

    task automatic bus_read(input logic [31:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
        #1;
    endtask

    task automatic rx_push(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = b;
        @(negedge clk);
        rx_valid = 1'b0;
        #1;
    endtask

    task automatic tx_accept();
        @(negedge clk);
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 tx_valid", {31'b0, tx_valid}, 32'h0);
        chk("R1 irq", {30'b0, irq_tx, irq_rx}, 32'h0);
        bus_read(PRI + 32'h0, d); chk("R1 rx status", d, 32'h0);
        bus_read(PRI + 32'h8, d); chk("R1 tx status", d, 32'h1);
    endtask

    task automatic t_rx_basic();
        logic [31:0] d;
        rx_push(8'hA5);
        bus_read(PRI + 32'h0, d); chk("R3 rx flag", d, 32'h1);
        bus_read(MIR + 32'h4, d); chk("R3 R2 rx data mirror", d, 32'h0000_00A5);
        bus_read(PRI + 32'h0, d); chk("R4 rx flag cleared", d, 32'h0);
    endtask

    task automatic t_rx_overwrite();
        logic [31:0] d;
        rx_push(8'h11);
        rx_push(8'h22);
        bus_read(PRI + 32'h0, d); chk("R5 flag stays", d, 32'h1);
        bus_read(PRI + 32'h4, d); chk("R5 newest byte", d, 32'h22);
    endtask

    task automatic t_rx_race();
        logic [31:0] d;
        rx_push(8'h33);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = PRI + 32'h4;
        rx_valid = 1'b1; rx_byte = 8'h44;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0; rx_valid = 1'b0;
        chk("R4 race old byte", d, 32'h33);
        bus_read(PRI + 32'h0, d); chk("R4 race flag kept", d, 32'h1);
        bus_read(PRI + 32'h4, d); chk("R4 race new byte", d, 32'h44);
    endtask

    task automatic t_rx_irq();
        logic [31:0] d;
        rx_push(8'h5C);
        chk("R6 irq off when disabled", {31'b0, irq_rx}, 32'h0);
        bus_write(PRI + 32'h0, 32'h2);
        chk("R6 irq on", {31'b0, irq_rx}, 32'h1);
        bus_read(PRI + 32'h0, d); chk("R6 status", d, 32'h3);
        bus_write(PRI + 32'h4, 32'h99);
        bus_read(PRI + 32'h4, d); chk("R11 rx data write ignored", d, 32'h5C);
        chk("R6 irq drops after read", {31'b0, irq_rx}, 32'h0);
        bus_write(PRI + 32'h0, 32'hFFFF_FFFD);
        bus_read(PRI + 32'h0, d); chk("R11 bit0 write ignored", d, 32'h0);
    endtask

    task automatic t_tx_basic();
        logic [31:0] d;
        bus_write(PRI + 32'hC, 32'hDEAD_BE5A);
        chk("R7 tx_valid", {31'b0, tx_valid}, 32'h1);
        chk("R7 tx_byte low byte", {24'b0, tx_byte}, 32'h5A);
        bus_read(PRI + 32'h8, d); chk("R7 tx status busy", d, 32'h0);
        repeat (3) @(negedge clk);
        #1;
        chk("R8 held valid", {31'b0, tx_valid}, 32'h1);
        chk("R8 held byte", {24'b0, tx_byte}, 32'h5A);
        bus_write(PRI + 32'hC, 32'h77);
        chk("R9 byte unchanged", {24'b0, tx_byte}, 32'h5A);
        tx_accept();
        chk("R8 valid dropped", {31'b0, tx_valid}, 32'h0);
        bus_read(PRI + 32'h8, d); chk("R8 ready again", d, 32'h1);
        chk("R9 no second byte", {31'b0, tx_valid}, 32'h0);
    endtask

    task automatic t_tx_irq();
        logic [31:0] d;
        bus_write(MIR + 32'h8, 32'hFFFF_FFFE);
        chk("R10 irq when ready", {31'b0, irq_tx}, 32'h1);
        bus_read(PRI + 32'h8, d); chk("R10 R11 status", d, 32'h3);
        bus_write(MIR + 32'hC, 32'h0000_0110);
        chk("R10 irq off while busy", {31'b0, irq_tx}, 32'h0);
        chk("R2 R7 mirror tx byte", {24'b0, tx_byte}, 32'h10);
        tx_accept();
        chk("R10 irq back", {31'b0, irq_tx}, 32'h1);
        bus_write(PRI + 32'h8, 32'h0);
        chk("R10 irq disabled", {31'b0, irq_tx}, 32'h0);
    endtask

    task automatic t_decode();
        logic [31:0] d;
        bus_write(PRI + 32'h1C, 32'h66);
        chk("R2 outside write no effect", {31'b0, tx_valid}, 32'h0);
        bus_read(PRI + 32'h18, d); chk("R2 outside read zero", d, 32'h0);
        rx_push(8'h7E);
        bus_read(32'hFFFF_8004, d); chk("R2 outside read of rx data", d, 32'h0);
        bus_read(MIR + 32'h0, d); chk("R2 flag untouched", d, 32'h1);
        bus_read(PRI + 32'h4, d); chk("R2 drain", d, 32'h7E);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_rx_basic();
        t_rx_overwrite();
        t_rx_race();
        t_rx_irq();
        t_tx_basic();
        t_tx_irq();
        t_decode();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule